// File: doc/BRIEF.md
# Clock Source Mode Sequencer

This block steps a system between three stable clocking modes: a low-power mode that runs from a slow internal oscillator, a mid-speed mode that runs from a crystal oscillator, and a full-speed mode that runs from a PLL. No source change happens in a single step. Going upward, the sequencer first enables the next source and waits in a settle state until that source is usable. It then asks the external glitch-free multiplexer to switch and waits in a handshake state until the multiplexer confirms. Going downward, it moves through a handshake state that releases the current source. Once the multiplexer acknowledges the release, the sequencer turns that source off.

Software or a power manager drives a two-bit mode request. The request is only examined in a stable mode, so a sequence that has started always runs to its end. A request for full speed issued from low power climbs through mid-speed on the way up. A request for low power issued from full speed steps down through mid-speed. Each settle state has a programmable down-counter. In the crystal settle state, either the counter or an oscillator-ready input can end the wait. In the PLL settle state, the counter and the lock input must both agree.

Top module: `clkseq_top`

## Requirements
- R1: A synchronous active-high reset puts the block in the low-power state: `state` = 0, `mode` = 0, and `osc_en`, `pll_en`, `sel_xtal_req` and `sel_pll_req` all low.
- R2: In low power (state 0), a `mode_req` of 1 (mid-speed) or 2 (full speed) moves the block to the crystal settle state (state 1) on the next edge. In that state `osc_en` is 1, both select requests are 0, and `mode` keeps its previous value.
- R3: The crystal settle state moves to the crystal switch state (state 2) when `xtal_on` is high. It also moves there when `xtal_to_en` is high and the counter has expired. The counter is loaded with `xtal_settle` = N when the settle state is entered, so with `xtal_on` low the state lasts N+1 cycles. With both `xtal_on` and `xtal_to_en` low, the block stays in the settle state.
- R4: In the crystal switch state, `sel_xtal_req` is 1. The block waits there until `xtal_sw_ack` is high, then enters mid-speed (state 3, `mode` = 1).
- R5: In mid-speed, a `mode_req` of 0 leads to the crystal release state (state 4). There `sel_xtal_req` is 0 and `osc_en` stays 1. The block waits until `xtal_sw_ack` is low, then enters low power with `osc_en` low and `mode` = 0.
- R6: In mid-speed, a `mode_req` of 2 leads to the PLL settle state (state 5). There `pll_en` and `sel_xtal_req` are 1 and `sel_pll_req` is 0. The state ends when `pll_on` is high and the PLL counter has expired, or when `pll_on` is high and `pll_to_en` is low. The PLL counter is loaded with `pll_settle` on entry, in the same way as the crystal counter.
- R7: The PLL switch state (state 6) drives `sel_pll_req` to 1 and waits for `pll_sw_ack` high. It then enters full speed (state 7, `mode` = 2).
- R8: In full speed, a `mode_req` of 0 or 1 leads to the PLL release state (state 8). There `sel_pll_req` is 0 and `pll_en` stays 1. The block waits for `pll_sw_ack` low, then enters mid-speed with `pll_en` low. If the request is still 0, the block continues down from mid-speed.
- R9: Changes of `mode_req` during states 1, 2, 4, 5, 6 and 8 are ignored, and the transition in progress completes.
- R10: A request equal to the current stable mode, or the reserved code 3, leaves a stable mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_req | input | 2 | Requested mode: 0 low power, 1 mid-speed, 2 full speed, 3 reserved |
| xtal_on | input | 1 | Crystal oscillator reports stable output |
| pll_on | input | 1 | PLL reports lock |
| xtal_sw_ack | input | 1 | Crystal multiplexer level: high when the crystal drives the clock |
| pll_sw_ack | input | 1 | PLL multiplexer level: high when the PLL drives the clock |
| xtal_to_en | input | 1 | Lets the crystal counter end the crystal settle state |
| pll_to_en | input | 1 | When low, the PLL settle state does not wait for its counter |
| xtal_settle | input | CNT_W | Crystal settle count |
| pll_settle | input | CNT_W | PLL settle count |
| mode | output | 2 | Last stable mode reached |
| state | output | 4 | Sequencer state code, 0 to 8 |
| osc_en | output | 1 | Crystal oscillator enable |
| pll_en | output | 1 | PLL enable |
| sel_xtal_req | output | 1 | Request crystal as clock source |
| sel_pll_req | output | 1 | Request PLL as clock source |

## Verification
The bench builds the block with `CNT_W` = 6, so the settle counts it uses (0, 2 and 3 cycles) finish within a few cycles. This brings the exact settle-state length within reach, including the zero count that exits after one cycle. The bench also keeps each acknowledgment line at its old level for extra cycles, which exposes any early exit from a handshake state. It changes requests during transitions and issues full-speed and low-power requests directly from the opposite extreme, so the chained climb and descent are both exercised.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;

  localparam int ST_W = 4;
  localparam int MD_W = 2;
  localparam int NUM_TMR = 2;
  localparam int TMR_XTAL = 0;
  localparam int TMR_PLL = 1;

  typedef enum logic [ST_W-1:0] {
    ST_DOZE        = 4'd0,
    ST_XTAL_SETTLE = 4'd1,
    ST_SW_TO_XTAL  = 4'd2,
    ST_SLOW        = 4'd3,
    ST_SW_FROM_XT  = 4'd4,
    ST_PLL_SETTLE  = 4'd5,
    ST_SW_TO_PLL   = 4'd6,
    ST_NORMAL      = 4'd7,
    ST_SW_FROM_PLL = 4'd8
  } seq_state_e;

  typedef enum logic [MD_W-1:0] {
    MR_DOZE   = 2'd0,
    MR_SLOW   = 2'd1,
    MR_NORMAL = 2'd2,
    MR_RSVD   = 2'd3
  } mode_code_e;

endpackage

// File: rtl/clkseq_timer.sv
module clkseq_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired = (cnt_q == '0);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3

endmodule

// File: rtl/clkseq_fsm.sv
module clkseq_fsm
  import clkseq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [MD_W-1:0]      mode_req,
  input  logic                 xtal_on,
  input  logic                 pll_on,
  input  logic                 xtal_sw_ack,
  input  logic                 pll_sw_ack,
  input  logic                 xtal_to_en,
  input  logic                 pll_to_en,
  input  logic [NUM_TMR-1:0]   tmr_expired,
  output seq_state_e           st_q,
  output seq_state_e           st_nxt,
  output logic [NUM_TMR-1:0]   tmr_load
);

  logic req_up, req_down_full, req_down_mid;

  assign req_up        = (mode_req == MR_SLOW) || (mode_req == MR_NORMAL);
  assign req_down_full = (mode_req == MR_DOZE) || (mode_req == MR_SLOW);
  assign req_down_mid  = (mode_req == MR_DOZE);

  always_comb begin
    st_nxt = st_q;
    case (st_q)
      ST_DOZE:
        if (req_up) st_nxt = ST_XTAL_SETTLE;
      ST_XTAL_SETTLE:
        if (xtal_on || (xtal_to_en && tmr_expired[TMR_XTAL])) st_nxt = ST_SW_TO_XTAL;
      ST_SW_TO_XTAL:
        if (xtal_sw_ack) st_nxt = ST_SLOW;
      ST_SLOW:
        if (req_down_mid) st_nxt = ST_SW_FROM_XT;
        else if (mode_req == MR_NORMAL) st_nxt = ST_PLL_SETTLE;
      ST_SW_FROM_XT:
        if (!xtal_sw_ack) st_nxt = ST_DOZE;
      ST_PLL_SETTLE:
        if (pll_on && (!pll_to_en || tmr_expired[TMR_PLL])) st_nxt = ST_SW_TO_PLL;
      ST_SW_TO_PLL:
        if (pll_sw_ack) st_nxt = ST_NORMAL;
      ST_NORMAL:
        if (req_down_full) st_nxt = ST_SW_FROM_PLL;
      ST_SW_FROM_PLL:
        if (!pll_sw_ack) st_nxt = ST_SLOW;
      default:
        st_nxt = ST_DOZE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= ST_DOZE;
    else     st_q <= st_nxt;
  end

  assign tmr_load[TMR_XTAL] = (st_nxt == ST_XTAL_SETTLE) && (st_q != ST_XTAL_SETTLE);
  assign tmr_load[TMR_PLL]  = (st_nxt == ST_PLL_SETTLE) && (st_q != ST_PLL_SETTLE);

  AST_XTAL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_XTAL_SETTLE && !xtal_on && !xtal_to_en) |=> (st_q == ST_XTAL_SETTLE)); // R3
  AST_XSW_WAIT: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SW_TO_XTAL && !xtal_sw_ack) |=> (st_q == ST_SW_TO_XTAL)); // R4
  AST_XREL_WAIT: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SW_FROM_XT && xtal_sw_ack) |=> (st_q == ST_SW_FROM_XT)); // R5
  AST_PLL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PLL_SETTLE && !pll_on) |=> (st_q == ST_PLL_SETTLE)); // R6
  AST_PSW_WAIT: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SW_TO_PLL && !pll_sw_ack) |=> (st_q == ST_SW_TO_PLL)); // R7
  AST_PREL_WAIT: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SW_FROM_PLL && pll_sw_ack) |=> (st_q == ST_SW_FROM_PLL)); // R8
  AST_SETTLE_ORDER: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_PLL_SETTLE) |=> (st_q == ST_PLL_SETTLE || st_q == ST_SW_TO_PLL)); // R9

endmodule

// File: rtl/clkseq_outreg.sv
module clkseq_outreg
  import clkseq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  seq_state_e      st_nxt,
  output logic [MD_W-1:0] mode,
  output logic            osc_en,
  output logic            pll_en,
  output logic            sel_xtal_req,
  output logic            sel_pll_req
);

  logic osc_d, pll_d, selx_d, selp_d;

  always_comb begin
    osc_d  = (st_nxt != ST_DOZE);
    pll_d  = (st_nxt == ST_PLL_SETTLE) || (st_nxt == ST_SW_TO_PLL) ||
             (st_nxt == ST_NORMAL)     || (st_nxt == ST_SW_FROM_PLL);
    selp_d = (st_nxt == ST_SW_TO_PLL)  || (st_nxt == ST_NORMAL);
    selx_d = pll_d || (st_nxt == ST_SW_TO_XTAL) || (st_nxt == ST_SLOW);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode         <= MR_DOZE;
      osc_en       <= 1'b0;
      pll_en       <= 1'b0;
      sel_xtal_req <= 1'b0;
      sel_pll_req  <= 1'b0;
    end else begin
      osc_en       <= osc_d;
      pll_en       <= pll_d;
      sel_xtal_req <= selx_d;
      sel_pll_req  <= selp_d;
      case (st_nxt)
        ST_DOZE:   mode <= MR_DOZE;
        ST_SLOW:   mode <= MR_SLOW;
        ST_NORMAL: mode <= MR_NORMAL;
        default:   mode <= mode;
      endcase
    end
  end

  AST_PLL_NEEDS_OSC: assert property (@(posedge clk) disable iff (rst)
    pll_en |-> osc_en); // R6
  AST_PSEL_NEEDS_XSEL: assert property (@(posedge clk) disable iff (rst)
    sel_pll_req |-> (sel_xtal_req && pll_en)); // R7
  AST_OSC_OFF_IN_DOZE: assert property (@(posedge clk) disable iff (rst)
    $fell(osc_en) |-> (mode == MR_DOZE)); // R5

endmodule

// File: rtl/clkseq_top.sv
module clkseq_top
  import clkseq_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode_req,
  input  logic             xtal_on,
  input  logic             pll_on,
  input  logic             xtal_sw_ack,
  input  logic             pll_sw_ack,
  input  logic             xtal_to_en,
  input  logic             pll_to_en,
  input  logic [CNT_W-1:0] xtal_settle,
  input  logic [CNT_W-1:0] pll_settle,
  output logic [1:0]       mode,
  output logic [3:0]       state,
  output logic             osc_en,
  output logic             pll_en,
  output logic             sel_xtal_req,
  output logic             sel_pll_req
);

  seq_state_e         st_q, st_nxt;
  logic [NUM_TMR-1:0] tmr_load, tmr_expired;
  logic [CNT_W-1:0]   tmr_val [NUM_TMR];

  assign tmr_val[TMR_XTAL] = xtal_settle;
  assign tmr_val[TMR_PLL]  = pll_settle;

  clkseq_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .mode_req    (mode_req),
    .xtal_on     (xtal_on),
    .pll_on      (pll_on),
    .xtal_sw_ack (xtal_sw_ack),
    .pll_sw_ack  (pll_sw_ack),
    .xtal_to_en  (xtal_to_en),
    .pll_to_en   (pll_to_en),
    .tmr_expired (tmr_expired),
    .st_q        (st_q),
    .st_nxt      (st_nxt),
    .tmr_load    (tmr_load)
  );

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    clkseq_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk      (clk),
      .rst      (rst),
      .load     (tmr_load[g]),
      .load_val (tmr_val[g]),
      .expired  (tmr_expired[g])
    );
  end

  clkseq_outreg u_out (
    .clk          (clk),
    .rst          (rst),
    .st_nxt       (st_nxt),
    .mode         (mode),
    .osc_en       (osc_en),
    .pll_en       (pll_en),
    .sel_xtal_req (sel_xtal_req),
    .sel_pll_req  (sel_pll_req)
  );

  assign state = st_q;

  AST_STABLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_SLOW && mode_req == MR_SLOW) |=> (st_q == ST_SLOW)); // R10

endmodule

// File: tb/clkseq_top_tb.sv
module clkseq_top_tb;

  localparam int CW = 6;

  localparam logic [3:0] S_DOZE = 4'd0, S_XS = 4'd1, S_SWX = 4'd2, S_SLOW = 4'd3,
                         S_RELX = 4'd4, S_PS = 4'd5, S_SWP = 4'd6, S_NORM = 4'd7,
                         S_RELP = 4'd8;

  typedef struct {
    logic [3:0] st;
    logic [1:0] md;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] mode_req = 2'd0;
  logic xtal_on = 1'b0, pll_on = 1'b0, xtal_sw_ack = 1'b0, pll_sw_ack = 1'b0;
  logic xtal_to_en = 1'b0, pll_to_en = 1'b0;
  logic [CW-1:0] xtal_settle = '0, pll_settle = '0;
  logic [1:0] mode;
  logic [3:0] state;
  logic osc_en, pll_en, sel_xtal_req, sel_pll_req;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  bit done = 1'b0;
  exp_t sb[$];

  always #2 clk = ~clk;

  clkseq_top #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst), .mode_req(mode_req), .xtal_on(xtal_on), .pll_on(pll_on),
    .xtal_sw_ack(xtal_sw_ack), .pll_sw_ack(pll_sw_ack), .xtal_to_en(xtal_to_en),
    .pll_to_en(pll_to_en), .xtal_settle(xtal_settle), .pll_settle(pll_settle),
    .mode(mode), .state(state), .osc_en(osc_en), .pll_en(pll_en),
    .sel_xtal_req(sel_xtal_req), .sel_pll_req(sel_pll_req)
  );

  function automatic logic [3:0] flags_for(input logic [3:0] s);
    logic o, p, x, q;
    o = (s != S_DOZE);
    p = (s == S_PS) || (s == S_SWP) || (s == S_NORM) || (s == S_RELP);
    x = p || (s == S_SWX) || (s == S_SLOW);
    q = (s == S_SWP) || (s == S_NORM);
    return {o, p, x, q};
  endfunction

  task automatic step(input logic [3:0] st, input logic [1:0] md, input string tag);
    exp_t e;
    @(posedge clk);
    #1;
    e.st = st; e.md = md; e.tag = tag;
    sb.push_back(e);
  endtask

  always @(negedge clk) begin
    while (sb.size() > 0) begin
      exp_t e;
      logic [9:0] act, want;
      e = sb.pop_front();
      act  = {state, mode, osc_en, pll_en, sel_xtal_req, sel_pll_req};
      want = {e.st, e.md, flags_for(e.st)};
      n_chk++;
      if (act !== want) begin
        n_bad++;
        $display("FAIL %s: {state,mode,osc,pll,selx,selp} actual %b expected %b", e.tag, act, want);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual cycle %0d expected end before 5000", cyc);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    step(S_DOZE, 0, "R1");
    step(S_DOZE, 0, "R1");
    rst = 1'b0;
    xtal_settle = 6'd3; pll_settle = 6'd2; xtal_to_en = 1'b1; pll_to_en = 1'b1;
    mode_req = 2'd1;
    step(S_XS, 0, "R2");
    step(S_XS, 0, "R3");
    step(S_XS, 0, "R3");
    step(S_XS, 0, "R3");
    step(S_SWX, 0, "R3");
    step(S_SWX, 0, "R4");
    xtal_sw_ack = 1'b1;
    step(S_SLOW, 1, "R4");
    mode_req = 2'd2;
    step(S_PS, 1, "R6");
    step(S_PS, 1, "R6");
    step(S_PS, 1, "R6");
    step(S_PS, 1, "R6");
    pll_on = 1'b1;
    step(S_SWP, 1, "R6");
    mode_req = 2'd0;
    step(S_SWP, 1, "R9");
    pll_sw_ack = 1'b1;
    step(S_NORM, 2, "R7");
    step(S_RELP, 2, "R8");
    step(S_RELP, 2, "R8");
    pll_sw_ack = 1'b0;
    step(S_SLOW, 1, "R8");
    step(S_RELX, 1, "R5");
    step(S_RELX, 1, "R5");
    xtal_sw_ack = 1'b0;
    step(S_DOZE, 0, "R5");
    step(S_DOZE, 0, "R10");
    mode_req = 2'd3;
    step(S_DOZE, 0, "R10");
    xtal_to_en = 1'b0; mode_req = 2'd2;
    step(S_XS, 0, "R2");
    for (int i = 0; i < 5; i++) step(S_XS, 0, "R3");
    xtal_on = 1'b1;
    step(S_SWX, 0, "R3");
    xtal_sw_ack = 1'b1;
    step(S_SLOW, 1, "R4");
    pll_to_en = 1'b0;
    step(S_PS, 1, "R6");
    step(S_SWP, 1, "R6");
    pll_sw_ack = 1'b1;
    step(S_NORM, 2, "R7");
    mode_req = 2'd3;
    step(S_NORM, 2, "R10");
    step(S_NORM, 2, "R10");
    mode_req = 2'd1;
    step(S_RELP, 2, "R8");
    pll_sw_ack = 1'b0;
    step(S_SLOW, 1, "R8");
    step(S_SLOW, 1, "R10");
    xtal_on = 1'b0; mode_req = 2'd0;
    step(S_RELX, 1, "R5");
    xtal_sw_ack = 1'b0;
    step(S_DOZE, 0, "R5");
    xtal_to_en = 1'b1; xtal_settle = 6'd0; mode_req = 2'd1;
    step(S_XS, 0, "R2");
    mode_req = 2'd0;
    step(S_SWX, 0, "R3");
    step(S_SWX, 0, "R9");
    xtal_sw_ack = 1'b1;
    step(S_SLOW, 1, "R9");
    step(S_RELX, 1, "R5");
    xtal_sw_ack = 1'b0;
    step(S_DOZE, 0, "R5");
    @(negedge clk);
    @(negedge clk);
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule